// File: doc/BRIEF.md
# Range-Matched Fully Associative Translation Buffer

This block is a small fully associative address translation buffer. Every slot stores an inclusive virtual range, given as a first and a last address, together with a physical page number, a set of protection attributes and a valid bit. A lookup compares one virtual address against every slot in parallel. The lowest-numbered slot whose range contains the address supplies the result. The physical page, the page offset and the attributes of that slot appear on registered outputs one clock after the request.

Software loads the buffer in two steps. The first is an address-insert command. It picks a slot, sets the slot's range to one 4 KiB page and its physical page number, and leaves the slot invalid. It reuses a slot that already covers the address. When no slot covers the address, it takes the slot named by a wrapping round-robin pointer. The second is a protection-insert command. It writes the attributes into the slot that covers the address and marks the slot valid. Two purge commands are provided. One drops the valid slot covering an address. The other clears every slot. Each command takes one clock.

A lookup and a command in the same cycle are allowed. The lookup then sees the contents from before the command.

Top module: `rangeTlb`

## Requirements
- R1: A slot covers an address when first <= address <= last, with both bounds inclusive. A lookup uses the covering slot with the lowest index. `lkDone` is high in the cycle after each cycle in which `lkReq` is high, and the result outputs are registered at that same edge.
- R2: A lookup is a miss when no slot covers the address, or when the covering slot is invalid. On a miss `lkHit` is 0 and every field output is 0.
- R3: An address insert whose address is covered by one or more slots clears every covering slot that is valid. It then writes into the lowest covering slot and leaves the round-robin pointer unchanged.
- R4: An address insert whose address is covered by no slot writes into the slot at the round-robin pointer and advances the pointer by one. After slot ENTRIES-1 the pointer wraps to slot 0. Reset sets the pointer to 0.
- R5: An address insert sets first = address with its low 12 bits cleared, last = first + 0xFFF, and the physical page number = data[24:5]. It clears all attributes and leaves the slot invalid.
- R6: A protection insert writes into the lowest slot covering the address and sets that slot valid. It loads access id = data[18:1], user = data[19], level-2 privilege = data[21:20], level-1 privilege = data[23:22], access type = data[26:24], break = data[27], dirty = data[28] and trap = data[29]. A hit reports `lkPhysAddr` = {page number, address[11:0]}.
- R7: A protection insert whose address no slot covers changes nothing. It raises `cmdErr` for one cycle, in the cycle after the command.
- R8: A purge-one command clears the lowest covering slot if that slot is valid, and otherwise does nothing. A purge-all command clears every slot.
- R9: A cleared slot has first = all ones and last = 0, so it covers no address. Reset leaves every slot cleared.
- R10: The opcode encodings are 0 = none, 1 = address insert, 2 = protection insert, 3 = purge one and 4 = purge all. The codes 5 to 7, and any cycle with `cmdValid` low, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | A command is present this cycle |
| cmdOp | input | 3 | Command opcode (R10) |
| cmdAddr | input | ADDR_W | Virtual address of the command |
| cmdData | input | 32 | Data word of the command |
| cmdErr | output | 1 | Protection insert found no covering slot |
| lkReq | input | 1 | Lookup request |
| lkAddr | input | ADDR_W | Virtual address to look up |
| lkDone | output | 1 | Lookup result valid |
| lkHit | output | 1 | Lookup found a valid covering slot |
| lkPpn | output | 20 | Physical page number |
| lkPhysAddr | output | 32 | Translated physical address |
| lkAccessId | output | 18 | Access id of the slot |
| lkUser | output | 1 | User attribute bit |
| lkPl2 | output | 2 | Level-2 privilege field |
| lkPl1 | output | 2 | Level-1 privilege field |
| lkType | output | 3 | Access type field |
| lkBrk | output | 1 | Break attribute bit |
| lkDirty | output | 1 | Dirty attribute bit |
| lkTrap | output | 1 | Trap attribute bit |

## Verification
Most internal faults show up at the ports as a changed hit or miss, or as a changed page number. A wrong range bound shows at the lookup that follows, at the last byte of a page or at the first byte past it. A round-robin pointer that fails to advance, advances too often or wraps in the wrong place does not show at once. It shows only after the buffer has been filled, when the next address insert evicts the wrong page. A later lookup of the page that should have survived then misses. Faults in the cleared state show as a protection insert that succeeds at address 0 or at the all-ones address, where `cmdErr` should rise one cycle later.

// File: rtl/rangeTlbPkg.sv
package rangeTlbPkg;

  localparam int DATA_W   = 32;
  localparam int PPN_W    = 20;
  localparam int PPN_LSB  = 5;
  localparam int AID_W    = 18;

  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_INS_ADDR  = 3'd1,
    OP_INS_PROT  = 3'd2,
    OP_PURGE_ONE = 3'd3,
    OP_PURGE_ALL = 3'd4
  } tlbOpE;

  typedef struct packed {
    logic [AID_W-1:0] accessId;
    logic             user;
    logic [1:0]       pl2;
    logic [1:0]       pl1;
    logic [2:0]       acc;
    logic             brk;
    logic             dirty;
    logic             trap;
  } tlbAttrT;

  typedef struct packed {
    logic wrAddr;
    logic wrProt;
    logic clrAll;
  } tlbStrobeT;

  function automatic tlbAttrT unpackAttr(input logic [DATA_W-1:0] d);
    tlbAttrT a;
    a.accessId = d[18:1];
    a.user     = d[19];
    a.pl2      = d[21:20];
    a.pl1      = d[23:22];
    a.acc      = d[26:24];
    a.brk      = d[27];
    a.dirty    = d[28];
    a.trap     = d[29];
    return a;
  endfunction

endpackage

// File: rtl/rangeTlbCtrl.sv
module rangeTlbCtrl
  import rangeTlbPkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [2:0]         cmdOp,
  input  logic [ENTRIES-1:0] coverVec,
  input  logic [ENTRIES-1:0] validVec,
  output tlbStrobeT          strobe,
  output logic [IDX_W-1:0]   tgtIdx,
  output logic [ENTRIES-1:0] killMask,
  output logic               cmdErr
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] firstCover;
  logic             anyCover;
  logic             errNext;
  logic             rrStep;

  // lowest covering slot
  always_comb begin
    firstCover = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (coverVec[i]) firstCover = IDX_W'(i);
    end
  end
  assign anyCover = |coverVec;

  always_comb begin
    strobe   = '0;
    tgtIdx   = firstCover;
    killMask = '0;
    errNext  = 1'b0;
    rrStep   = 1'b0;
    if (cmdValid) begin
      case (cmdOp)
        OP_INS_ADDR: begin
          strobe.wrAddr = 1'b1;
          killMask      = coverVec & validVec;
          if (!anyCover) begin
            tgtIdx = rrPtr;
            rrStep = 1'b1;
          end
        end
        OP_INS_PROT: begin
          if (anyCover) strobe.wrProt = 1'b1;
          else          errNext       = 1'b1;
        end
        OP_PURGE_ONE: begin
          for (int i = 0; i < ENTRIES; i++) begin
            killMask[i] = anyCover && (IDX_W'(i) == firstCover) && validVec[i];
          end
        end
        OP_PURGE_ALL: strobe.clrAll = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr  <= '0;
      cmdErr <= 1'b0;
    end else begin
      cmdErr <= errNext;
      if (rrStep) rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrAddr, strobe.wrProt, strobe.clrAll})); // R10
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdErr) |-> $past(cmdValid && cmdOp == OP_INS_PROT && !anyCover)); // R7
  AST_REUSE_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrAddr && anyCover) |=> $stable(rrPtr)); // R3
  AST_PTR_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrAddr && !anyCover) |=> !$stable(rrPtr)); // R4

endmodule

// File: rtl/rangeTlbStore.sv
module rangeTlbStore
  import rangeTlbPkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int PA_W  = PPN_W + PAGE_BITS
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlbStrobeT          strobe,
  input  logic [IDX_W-1:0]   tgtIdx,
  input  logic [ENTRIES-1:0] killMask,
  input  logic [ADDR_W-1:0]  cmdAddr,
  input  logic [DATA_W-1:0]  cmdData,
  output logic [ENTRIES-1:0] coverVec,
  output logic [ENTRIES-1:0] validVec,
  input  logic               lkReq,
  input  logic [ADDR_W-1:0]  lkAddr,
  output logic               lkDone,
  output logic               lkHit,
  output logic [PPN_W-1:0]   lkPpn,
  output logic [PA_W-1:0]    lkPhysAddr,
  output tlbAttrT            lkAttr
);

  localparam logic [ADDR_W-1:0] OFFS_MASK =
    {{(ADDR_W - PAGE_BITS){1'b0}}, {PAGE_BITS{1'b1}}};

  logic [ADDR_W-1:0] vaFirst [ENTRIES];
  logic [ADDR_W-1:0] vaLast  [ENTRIES];
  logic [PPN_W-1:0]  ppnArr  [ENTRIES];
  tlbAttrT           attrArr [ENTRIES];
  logic [ENTRIES-1:0] lkCover;
  logic [ADDR_W-1:0] pageBase;

  assign pageBase = cmdAddr & ~OFFS_MASK;

  for (genvar g = 0; g < ENTRIES; g++) begin : gSlot
    logic isTgt;
    assign isTgt       = (tgtIdx == IDX_W'(g));
    assign coverVec[g] = (vaFirst[g] <= cmdAddr) && (cmdAddr <= vaLast[g]);
    assign lkCover[g]  = (vaFirst[g] <= lkAddr) && (lkAddr <= vaLast[g]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vaFirst[g]  <= '1;
        vaLast[g]   <= '0;
        ppnArr[g]   <= '0;
        attrArr[g]  <= '0;
        validVec[g] <= 1'b0;
      end else if (strobe.wrAddr && isTgt) begin
        vaFirst[g]  <= pageBase;
        vaLast[g]   <= pageBase | OFFS_MASK;
        ppnArr[g]   <= cmdData[PPN_LSB +: PPN_W];
        attrArr[g]  <= '0;
        validVec[g] <= 1'b0;
      end else if (strobe.clrAll || killMask[g]) begin
        vaFirst[g]  <= '1;
        vaLast[g]   <= '0;
        ppnArr[g]   <= '0;
        attrArr[g]  <= '0;
        validVec[g] <= 1'b0;
      end else if (strobe.wrProt && isTgt) begin
        attrArr[g]  <= unpackAttr(cmdData);
        validVec[g] <= 1'b1;
      end
    end
  end

  // lookup priority select
  logic [IDX_W-1:0] lkSel;
  logic             lkFound;
  always_comb begin
    lkSel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lkCover[i]) lkSel = IDX_W'(i);
    end
  end
  assign lkFound = (|lkCover) && validVec[lkSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lkDone     <= 1'b0;
      lkHit      <= 1'b0;
      lkPpn      <= '0;
      lkPhysAddr <= '0;
      lkAttr     <= '0;
    end else begin
      lkDone <= lkReq;
      if (lkReq && lkFound) begin
        lkHit      <= 1'b1;
        lkPpn      <= ppnArr[lkSel];
        lkPhysAddr <= {ppnArr[lkSel], lkAddr[PAGE_BITS-1:0]};
        lkAttr     <= attrArr[lkSel];
      end else begin
        lkHit      <= 1'b0;
        lkPpn      <= '0;
        lkPhysAddr <= '0;
        lkAttr     <= '0;
      end
    end
  end

  AST_LK_DONE: assert property (@(posedge clk) disable iff (!rstN)
    lkReq |=> lkDone); // R1
  AST_HIT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> lkDone); // R2
  AST_INS_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrAddr |=> !validVec[$past(tgtIdx)]); // R5
  AST_CLR_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrAll |=> (validVec == '0)); // R8
  AST_PROT_VALID: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrProt |=> validVec[$past(tgtIdx)]); // R6

endmodule

// File: rtl/rangeTlb.sv
module rangeTlb
  import rangeTlbPkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int PA_W  = PPN_W + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  output logic              cmdErr,
  input  logic              lkReq,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              lkDone,
  output logic              lkHit,
  output logic [PPN_W-1:0]  lkPpn,
  output logic [PA_W-1:0]   lkPhysAddr,
  output logic [AID_W-1:0]  lkAccessId,
  output logic              lkUser,
  output logic [1:0]        lkPl2,
  output logic [1:0]        lkPl1,
  output logic [2:0]        lkType,
  output logic              lkBrk,
  output logic              lkDirty,
  output logic              lkTrap
);

  tlbStrobeT          strobe;
  logic [IDX_W-1:0]   tgtIdx;
  logic [ENTRIES-1:0] killMask;
  logic [ENTRIES-1:0] coverVec;
  logic [ENTRIES-1:0] validVec;
  tlbAttrT            lkAttr;

  rangeTlbCtrl #(.ENTRIES(ENTRIES)) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .coverVec(coverVec), .validVec(validVec), .strobe(strobe),
    .tgtIdx(tgtIdx), .killMask(killMask), .cmdErr(cmdErr)
  );

  rangeTlbStore #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) i_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tgtIdx(tgtIdx),
    .killMask(killMask), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .coverVec(coverVec), .validVec(validVec), .lkReq(lkReq),
    .lkAddr(lkAddr), .lkDone(lkDone), .lkHit(lkHit), .lkPpn(lkPpn),
    .lkPhysAddr(lkPhysAddr), .lkAttr(lkAttr)
  );

  assign lkAccessId = lkAttr.accessId;
  assign lkUser     = lkAttr.user;
  assign lkPl2      = lkAttr.pl2;
  assign lkPl1      = lkAttr.pl1;
  assign lkType     = lkAttr.acc;
  assign lkBrk      = lkAttr.brk;
  assign lkDirty    = lkAttr.dirty;
  assign lkTrap     = lkAttr.trap;

endmodule

// File: tb/test_rangeTlb.sv
module test_rangeTlb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = '0;
  logic [31:0] cmdAddr = '0;
  logic [31:0] cmdData = '0;
  logic        cmdErr;
  logic        lkReq = 1'b0;
  logic [31:0] lkAddr = '0;
  logic        lkDone, lkHit;
  logic [19:0] lkPpn;
  logic [31:0] lkPhysAddr;
  logic [17:0] lkAccessId;
  logic        lkUser, lkBrk, lkDirty, lkTrap;
  logic [1:0]  lkPl2, lkPl1;
  logic [2:0]  lkType;

  int total = 0;
  int bad = 0;
  bit errSeen;

  rangeTlb i_rangeTlb (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .cmdErr(cmdErr),
    .lkReq(lkReq), .lkAddr(lkAddr), .lkDone(lkDone), .lkHit(lkHit),
    .lkPpn(lkPpn), .lkPhysAddr(lkPhysAddr), .lkAccessId(lkAccessId),
    .lkUser(lkUser), .lkPl2(lkPl2), .lkPl1(lkPl1), .lkType(lkType),
    .lkBrk(lkBrk), .lkDirty(lkDirty), .lkTrap(lkTrap)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] protWord(input logic [17:0] aid, input logic u,
      input logic [1:0] pl2, input logic [1:0] pl1, input logic [2:0] ty,
      input logic b, input logic d, input logic t);
    return ({31'd0, t} << 29) | ({31'd0, d} << 28) | ({31'd0, b} << 27) |
           ({29'd0, ty} << 24) | ({30'd0, pl1} << 22) | ({30'd0, pl2} << 20) |
           ({31'd0, u} << 19) | ({14'd0, aid} << 1);
  endfunction

  // issue one command; errSeen holds cmdErr in the following cycle
  task automatic doCmd(input logic [2:0] op, input logic [31:0] a, input logic [31:0] d);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; cmdData = d;
    @(negedge clk);
    errSeen = cmdErr;
    cmdValid = 1'b0; cmdOp = '0;
  endtask

  task automatic doLookup(input logic [31:0] a);
    lkReq = 1'b1; lkAddr = a;
    @(negedge clk);
    lkReq = 1'b0;
  endtask

  task automatic expectMiss(input string tag, input logic [31:0] a);
    doLookup(a);
    check({tag, " done"}, lkDone, 1);
    check({tag, " hit"}, lkHit, 0);
    check({tag, " ppn"}, lkPpn, 0);
  endtask

  task automatic expectHit(input string tag, input logic [31:0] a, input logic [19:0] ppn);
    doLookup(a);
    check({tag, " hit"}, lkHit, 1);
    check({tag, " ppn"}, lkPpn, ppn);
    check({tag, " phys"}, lkPhysAddr, {ppn, a[11:0]});
  endtask

  task automatic insPage(input logic [31:0] a, input logic [19:0] ppn, input logic [31:0] pw);
    doCmd(3'd1, a, {7'd0, ppn, 5'd0});
    doCmd(3'd2, a, pw);
  endtask

  function automatic logic [31:0] pageK(input int k);
    return 32'h0010_0000 + 32'(k) * 32'h1000;
  endfunction

  task automatic testReset();
    check("R9 reset err", cmdErr, 0);
    check("R9 reset done", lkDone, 0);
    expectMiss("R9 reset addr0", 32'h0);
    expectMiss("R9 reset allones", 32'hFFFF_FFFF);
  endtask

  task automatic testInsert();
    logic [31:0] pw;
    pw = protWord(18'h2A5A5, 1, 2'd2, 2'd1, 3'd5, 1, 0, 1);
    doCmd(3'd1, 32'h0001_2345, {7'd0, 20'hABCDE, 5'h1F});
    check("R7 no err on addr insert", errSeen, 0);
    expectMiss("R5 invalid after addr insert", 32'h0001_2345);
    doCmd(3'd2, 32'h0001_2000, pw);
    check("R6 no err", errSeen, 0);
    expectHit("R6 hit last byte", 32'h0001_2FFF, 20'hABCDE);
    check("R6 aid", lkAccessId, 18'h2A5A5);
    check("R6 user", lkUser, 1);
    check("R6 pl2", lkPl2, 2);
    check("R6 pl1", lkPl1, 1);
    check("R6 type", lkType, 5);
    check("R6 brk", lkBrk, 1);
    check("R6 dirty", lkDirty, 0);
    check("R6 trap", lkTrap, 1);
    expectHit("R5 first byte", 32'h0001_2000, 20'hABCDE);
    expectMiss("R1 past last", 32'h0001_3000);
    expectMiss("R1 below first", 32'h0001_1FFF);
    @(negedge clk);
    check("R1 done drops", lkDone, 0);
  endtask

  task automatic testProtMiss();
    doCmd(3'd2, 32'h5000_0000, 32'h3FFF_FFFF);
    check("R7 err raised", errSeen, 1);
    @(negedge clk);
    check("R7 err one cycle", cmdErr, 0);
    expectHit("R7 state unchanged", 32'h0001_2010, 20'hABCDE);
    check("R7 aid unchanged", lkAccessId, 18'h2A5A5);
    expectMiss("R7 no new slot", 32'h5000_0000);
  endtask

  task automatic testBadOp();
    doCmd(3'd7, 32'h0001_2000, 32'h0);
    doCmd(3'd5, 32'h0001_2000, 32'h0);
    cmdValid = 1'b0; cmdOp = 3'd4; cmdAddr = 32'h0001_2000;
    @(negedge clk);
    cmdOp = 3'd0;
    expectHit("R10 ignored ops", 32'h0001_2000, 20'hABCDE);
  endtask

  task automatic testReuseAndRr();
    doCmd(3'd1, 32'h0001_2800, {7'd0, 20'h11111, 5'd0});
    expectMiss("R3 covering slot invalidated", 32'h0001_2000);
    doCmd(3'd2, 32'h0001_2000, protWord(18'h1, 0, 0, 0, 3'd1, 0, 1, 0));
    expectHit("R3 reused slot", 32'h0001_2ABC, 20'h11111);
    for (int k = 1; k < NUM; k++) insPage(pageK(k), 20'(32'h100 + k), 32'h1000_0000);
    expectHit("R4 slot0 kept before wrap", 32'h0001_2000, 20'h11111);
    expectHit("R4 page1 present", pageK(1), 20'h101);
    insPage(pageK(NUM), 20'h1FF, 32'h1000_0000);
    expectMiss("R4 wrap evicts slot0", 32'h0001_2000);
    expectHit("R4 new page", pageK(NUM), 20'h1FF);
    expectHit("R4 page1 survives", pageK(1), 20'h101);
    insPage(pageK(NUM + 1), 20'h2EE, 32'h1000_0000);
    expectMiss("R4 next evicts slot1", pageK(1));
    expectHit("R4 page2 survives", pageK(2), 20'h102);
  endtask

  task automatic testPurge();
    doCmd(3'd3, pageK(2) + 32'h44, 32'h0);
    expectMiss("R8 purge one", pageK(2));
    expectHit("R8 neighbour kept", pageK(3), 20'h103);
    doCmd(3'd3, 32'h7000_0000, 32'h0);
    expectHit("R8 purge no cover", pageK(3), 20'h103);
    doCmd(3'd4, 32'h0, 32'h0);
    expectMiss("R8 purge all p3", pageK(3));
    expectMiss("R8 purge all pN", pageK(NUM));
    doCmd(3'd2, 32'h0, 32'h0);
    check("R9 cleared slot no match at 0", errSeen, 1);
    doCmd(3'd2, 32'hFFFF_FFFF, 32'h0);
    check("R9 cleared slot no match at ones", errSeen, 1);
    expectMiss("R2 miss after clear", 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testInsert();
    testProtMiss();
    testBadOp();
    testReuseAndRr();
    testPurge();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule